// File: doc/BRIEF.md
# Phase-Presettable Triangle Ramp Counter

This block produces a digital triangle ramp that climbs from 0 to 1000 and falls back again, together with a square wave that marks the ramp's slope and its complement. The count advances by exactly one step on each single-cycle event pulse from an upstream rate divider. When it reaches either end of the range, it turns back without overshooting the end and without repeating the endpoint. One full ramp cycle therefore takes 2000 events. The parallel count feeds an external subtractive DAC, in which code 1000 is the negative peak and code 0 is the positive peak.

A host stores a starting phase through a write strobe. Values above 1000 are clamped to 1000. A load strobe then presets the count from the stored phase and forces the slope to falling, so every new run starts on the down slope. A hold input freezes both the count and the slope. When hold is released, the ramp resumes in the direction it had before the hold. All logic is synchronous to one clock, with a synchronous active-high reset.

Top module: `tri_ramp_gen`

## Requirements
- R1: After reset the count is 0, `sq_out` is 0 and `sq_n_out` is 1.
- R2: A phase write stores `phase_din`, clamped to 1000 when it is larger. A later `load` makes `count_out` equal to the stored value on the next cycle.
- R3: `load` forces the slope to falling (`sq_out` = 0) on the next cycle. The first event after a load decrements the count, unless the count is 0.
- R4: An event taken with `hold` and `load` low changes the count by exactly one. A cycle with no event leaves the count and the slope unchanged.
- R5: The count never exceeds 1000. The event that reaches 1000 clears `sq_out` in the same update, and the next event gives 999.
- R6: The event that reaches 0 sets `sq_out` in the same update, and the next event gives 1.
- R7: Over a free-running sequence the count spans exactly 0 to 1000, and the pattern repeats every 2000 events.
- R8: While `hold` is high, events change neither the count nor the slope. After release, the ramp continues in the slope it had before the hold.
- R9: `sq_n_out` is always the inverse of `sq_out`.
- R10: A phase write on its own, without `load`, leaves the count and the slope untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_wr | input | 1 | Write strobe for the starting phase |
| phase_din | input | 10 | Starting phase value |
| load | input | 1 | Preset the count from the stored phase and force the slope to falling |
| evt | input | 1 | Single-cycle step event from the rate divider |
| hold | input | 1 | Freeze the count and the slope |
| count_out | output | 10 | Ramp code for the DAC (1000 is the negative peak) |
| sq_out | output | 1 | Slope square wave (1 = rising) |
| sq_n_out | output | 1 | Complement of `sq_out` |

## Verification
A wrong slope flip-flop shows up on `sq_out` in the very next cycle. On the first event it then appears as a count moving the wrong way, or as a count stepping past 0 or 1000. A wrong preset or a wrong clamp is visible in `count_out` one cycle after `load`. An off-by-one in turning at an endpoint shifts the whole pattern, so the 2000-event period drifts and the count diverges from the bench's position model within a single ramp.

// File: rtl/tri_ramp_pkg.sv
package tri_ramp_pkg;
  localparam int CODE_W    = 10;
  localparam int PEAK_CODE = 1000;
endpackage

// File: rtl/tri_phase_hold.sv
module tri_phase_hold #(
  parameter int W    = tri_ramp_pkg::CODE_W,
  parameter int PEAK = tri_ramp_pkg::PEAK_CODE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic [W-1:0] phase
);
  localparam logic [W-1:0] TOP = W'(PEAK);

  function automatic logic [W-1:0] clamp_code(input logic [W-1:0] v);
    return (v > TOP) ? TOP : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     phase <= '0;
    else if (wr) phase <= clamp_code(din);
  end

  assert_clamp_R2: assert property (@(posedge clk) disable iff (rst)
    phase <= TOP);

  assert_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr |=> (phase == (($past(din) > TOP) ? TOP : $past(din))));
endmodule

// File: rtl/tri_step_core.sv
module tri_step_core #(
  parameter int W    = tri_ramp_pkg::CODE_W,
  parameter int PEAK = tri_ramp_pkg::PEAK_CODE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] preset,
  input  logic         evt,
  input  logic         hold,
  output logic [W-1:0] cnt_q,
  output logic         dir_up_q
);
  localparam logic [W-1:0] TOP = W'(PEAK);

  function automatic logic [W-1:0] move_code(input logic [W-1:0] cur, input logic up);
    return up ? cur + 1'b1 : cur - 1'b1;
  endfunction

  wire ev_step = evt & ~hold & ~load;
  wire at_top  = (cnt_q == TOP);
  wire at_bot  = (cnt_q == '0);

  logic         eff_up;
  logic [W-1:0] nxt_cnt;
  logic         nxt_dir;

  always_comb begin
    eff_up  = at_bot ? 1'b1 : (at_top ? 1'b0 : dir_up_q);
    nxt_cnt = move_code(cnt_q, eff_up);
    if (nxt_cnt == '0)       nxt_dir = 1'b1;
    else if (nxt_cnt == TOP) nxt_dir = 1'b0;
    else                     nxt_dir = eff_up;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b0;
    end else if (load) begin
      cnt_q    <= preset;
      dir_up_q <= 1'b0;
    end else if (ev_step) begin
      cnt_q    <= nxt_cnt;
      dir_up_q <= nxt_dir;
    end
  end

  assert_range_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP);

  assert_top_down_R5: assert property (@(posedge clk) disable iff (rst)
    at_top |-> !dir_up_q);

  assert_load_down_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> !dir_up_q);

  assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
    ev_step |=> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1)));

  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (!evt && !load) |=> ($stable(cnt_q) && $stable(dir_up_q)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (hold && !load) |=> ($stable(cnt_q) && $stable(dir_up_q)));

  assert_bottom_up_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_step && cnt_q == W'(1) && !dir_up_q) |=> (cnt_q == '0 && dir_up_q));
endmodule

// File: rtl/tri_ramp_gen.sv
module tri_ramp_gen #(
  parameter int W    = tri_ramp_pkg::CODE_W,
  parameter int PEAK = tri_ramp_pkg::PEAK_CODE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         phase_wr,
  input  logic [W-1:0] phase_din,
  input  logic         load,
  input  logic         evt,
  input  logic         hold,
  output logic [W-1:0] count_out,
  output logic         sq_out,
  output logic         sq_n_out
);
  logic [W-1:0] phase_val;
  logic [W-1:0] cnt;
  logic         dir_up;

  tri_phase_hold #(.W(W), .PEAK(PEAK)) u_phase (
    .clk(clk), .rst(rst), .wr(phase_wr), .din(phase_din), .phase(phase_val)
  );

  tri_step_core #(.W(W), .PEAK(PEAK)) u_core (
    .clk(clk), .rst(rst), .load(load), .preset(phase_val),
    .evt(evt), .hold(hold), .cnt_q(cnt), .dir_up_q(dir_up)
  );

  assign count_out = cnt;
  assign sq_out    = dir_up;
  assign sq_n_out  = ~dir_up;

  assert_preset_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_out == $past(phase_val)));

  assert_wr_only_R10: assert property (@(posedge clk) disable iff (rst)
    (phase_wr && !load && !evt) |=> ($stable(count_out) && $stable(sq_out)));
endmodule

// File: tb/tri_ramp_gen_tb.sv
module tri_ramp_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PK = 1000;

  logic       clk = 1'b0;
  logic       rst, phase_wr, load, evt, hold;
  logic [9:0] phase_din;
  logic [9:0] count_out;
  logic       sq_out, sq_n_out;

  int total = 0;
  int bad   = 0;
  int seen_max = 0;
  int seen_min = 1023;

  typedef struct { int cnt; bit sq; string tag; } exp_t;
  exp_t exp_q[$];

  // bench model: position on a 2000-event circle
  int  m_pos   = 0;
  bit  m_force = 1'b1;
  int  m_phase = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_ramp_gen u_dut (
    .clk(clk), .rst(rst), .phase_wr(phase_wr), .phase_din(phase_din),
    .load(load), .evt(evt), .hold(hold),
    .count_out(count_out), .sq_out(sq_out), .sq_n_out(sq_n_out)
  );

  function automatic int ramp_of(input int p);
    return (p <= PK) ? p : 2 * PK - p;
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic step(input bit r, input bit ld, input bit ev, input bit hd,
                      input bit wr, input int d, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; load = ld; evt = ev; hold = hd; phase_wr = wr; phase_din = 10'(d);
    if (r) begin
      m_pos = 0; m_force = 1'b1; m_phase = 0;
    end else begin
      if (ld) begin
        m_pos = (m_phase == 0) ? 0 : 2 * PK - m_phase;
        m_force = 1'b1;
      end else if (ev && !hd) begin
        m_pos = (m_pos + 1) % (2 * PK);
        m_force = 1'b0;
      end
      if (wr) m_phase = (d > PK) ? PK : d;
    end
    e.cnt = ramp_of(m_pos);
    e.sq  = m_force ? 1'b0 : (m_pos < PK);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compares each result one cycle after it was driven
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(count_out == 10'(e.cnt), e.tag, "count", int'(count_out), e.cnt);
      check(sq_out == e.sq, e.tag, "sq", int'(sq_out), int'(e.sq));
      check(sq_n_out == ~sq_out, "R9", "sq_n", int'(sq_n_out), int'(~sq_out));
      if (!rst) begin
        if (int'(count_out) > seen_max) seen_max = int'(count_out);
        if (int'(count_out) < seen_min) seen_min = int'(count_out);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; load = 1'b0; evt = 1'b0; hold = 1'b0; phase_wr = 1'b0; phase_din = '0;
    // R1 reset state
    step(1, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");
    // R7 free run over more than one full period, covering both turns (R5, R6)
    for (int i = 0; i < 2100; i++) step(0, 0, 1, 0, 0, 0, "R7");
    // R4 gaps between events
    for (int i = 0; i < 30; i++) step(0, 0, (i % 3) == 0, 0, 0, 0, "R4");
    // R10 phase write alone, also with an oversize value that must clamp (R2)
    step(0, 0, 0, 0, 1, 1023, "R10");
    step(0, 0, 0, 0, 0, 0, "R10");
    // R2 clamped preset, R3 forced down start
    step(0, 1, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 1, 300, "R10");
    step(0, 1, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 310; i++) step(0, 0, 1, 0, 0, 0, "R3");
    // R8 hold on rising slope
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1, 0, 0, "R8");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 0, "R8");
    // R3 load of zero starts down, then turns up at once (R6)
    step(0, 0, 0, 0, 1, 0, "R10");
    step(0, 1, 1, 0, 0, 0, "R3");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, "R6");
    // R8 hold on falling slope
    step(0, 0, 0, 0, 1, 600, "R10");
    step(0, 1, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, "R3");
    for (int i = 0; i < 7; i++) step(0, 0, 1, 1, 0, 0, "R8");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, "R8");
    // load at the top: down straight away
    step(0, 0, 0, 0, 1, 1000, "R10");
    step(0, 1, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, "R4");
    // R7 peak-to-peak span
    check(seen_max == PK, "R7", "max", seen_max, PK);
    check(seen_min == 0, "R7", "min", seen_min, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule